// File: doc/BRIEF.md
# Funnel Shifter and Byte-Lane Unit

This block is the shift and byte-handling slice of a 32-bit integer ALU. It keeps a small status word holding a funnel count and a byte pointer. Using those two fields it computes one of three results from two operands. A funnel extract shifts the concatenation of the two operands left by the count and keeps the upper word. A byte get pulls the byte lane named by the pointer out of the first operand and merges it into the low byte of the second operand. A byte put writes the low byte of the second operand into the pointed lane of the first operand.

Software can load the status word whole in one write, or write either field through its own strobe. The data path is purely combinational and always reads the value the register holds now.

With both operands equal, the funnel extract becomes a left rotate. Take pointer 1 and count 24. Running extract, then byte get, then byte put reverses the byte order of a word in three operations.

Top module: `shift_lane_unit`

## Requirements
- R1: The status word is 7 bits. The count is bits [4:0] and the pointer is bits [6:5]. A full write loads both fields on the clock edge, so writing 56 gives pointer 1 and count 24.
- R2: The count strobe updates only the count, and the pointer strobe updates only the pointer. The other field keeps its value.
- R3: When the full write and a field strobe are raised in the same cycle, the full write sets both fields.
- R4: A synchronous reset clears both fields to zero. Reset takes priority over every write.
- R5: A status write becomes visible only after the clock edge. Before that edge, the result is computed from the old field values.
- R6: Opcode 0 (funnel) returns the upper 32 bits of the 64-bit value {src_a, src_b} shifted left by the count. This holds for all 32 count values.
- R7: A funnel with count 0 returns src_a unchanged.
- R8: A funnel with src_a equal to src_b returns src_a rotated left by the count. For example, bytes a,b,c,d with count 24 give d,a,b,c.
- R9: Opcode 1 (byte get) places lane p of src_a in bits [7:0] and keeps bits [31:8] of src_b. Lanes are numbered from the top: lane 0 is bits [31:24] and lane 3 is bits [7:0].
- R10: Opcode 2 (byte put) writes bits [7:0] of src_b into lane p of src_a, using the same lane numbering. All other lanes of src_a pass through unchanged.
- R11: Opcode 3 returns zero.
- R12: With pointer 1 and count 24, the following sequence gives x byte-reversed. First compute t = funnel(x, x). Then compute u = get(t, t). Then compute put(u, t).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_wr | input | 1 | Full status-word write strobe |
| stat_wdata | input | 7 | Status word: pointer in [6:5], count in [4:0] |
| cnt_wr | input | 1 | Count-only write strobe |
| cnt_wdata | input | 5 | New count value |
| ptr_wr | input | 1 | Pointer-only write strobe |
| ptr_wdata | input | 2 | New pointer value |
| op | input | 2 | 0 funnel, 1 byte get, 2 byte put, 3 zero |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| result | output | 32 | Operation result |

## Verification
The bench builds the unit with a 32-bit word and 8-bit lanes. This gives 32 count values and 4 pointer values, which is small enough to sweep every combination against a shift-and-mask model. The bench's FUNNEL_IMPL parameter chooses between the staged funnel (the default) and the single-shift variant, so either variant can be run through the same sweep. Random words are passed through the three-operation byte-reverse sequence. The bench also exercises simultaneous strobes, reset during a write, and the cycle just before a write lands.

// File: rtl/shift_lane_pkg.sv
package shift_lane_pkg;
   typedef enum logic [1:0] {
      OP_FUNNEL   = 2'd0,
      OP_BYTE_GET = 2'd1,
      OP_BYTE_PUT = 2'd2,
      OP_NONE     = 2'd3
   } lane_op_e;
endpackage

// File: rtl/shift_status_reg.sv
module shift_status_reg #(
   parameter int CNT_W = 5,
   parameter int PTR_W = 2,
   localparam int STAT_W = CNT_W + PTR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              full_wr,
   input  logic [STAT_W-1:0] full_data,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_data,
   input  logic              ptr_wr,
   input  logic [PTR_W-1:0]  ptr_data,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [PTR_W-1:0]  ptr_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         ptr_q <= '0;
      end else if (full_wr) begin
         cnt_q <= full_data[CNT_W-1:0];
         ptr_q <= full_data[STAT_W-1:CNT_W];
      end else begin
         if (cnt_wr) cnt_q <= cnt_data;
         if (ptr_wr) ptr_q <= ptr_data;
      end
   end

   assert_reset_clear_R4: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (cnt_q == '0 && ptr_q == '0));

   assert_full_load_R3: assert property (@(posedge clk) disable iff (rst)
      ($past(full_wr) && !$past(rst)) |-> ({ptr_q, cnt_q} == $past(full_data)));

   assert_ptr_kept_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(full_wr) && !$past(ptr_wr)) |-> (ptr_q == $past(ptr_q)));

   assert_cnt_kept_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(full_wr) && !$past(cnt_wr)) |-> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/funnel_extract.sv
module funnel_extract #(
   parameter int DATA_W      = 32,
   parameter int FUNNEL_IMPL = 1,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] hi_in,
   input  logic [DATA_W-1:0] lo_in,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] out
);
   if (FUNNEL_IMPL == 0) begin : g_single
      always_comb begin
         if (cnt == '0) out = hi_in;
         else out = (hi_in << cnt) | (lo_in >> (DATA_W - int'(cnt)));
      end
   end else begin : g_staged
      logic [DATA_W-1:0] hi_st [0:CNT_W];
      logic [DATA_W-1:0] lo_st [0:CNT_W-1];
      assign hi_st[0] = hi_in;
      assign lo_st[0] = lo_in;
      for (genvar k = 0; k < CNT_W; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign hi_st[k+1] = cnt[k] ? ((hi_st[k] << SH) | (lo_st[k] >> (DATA_W - SH)))
                                    : hi_st[k];
         if (k < CNT_W - 1) begin : g_lo
            assign lo_st[k+1] = cnt[k] ? (lo_st[k] << SH) : lo_st[k];
         end
      end
      assign out = hi_st[CNT_W];
   end
endmodule

// File: rtl/lane_merge.sv
module lane_merge #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W,
   localparam int PTR_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [PTR_W-1:0]  ptr,
   output logic [DATA_W-1:0] get_out,
   output logic [DATA_W-1:0] put_out
);
   logic [LANE_W-1:0] lane_a [0:LANES-1];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int TOP = DATA_W - 1 - i * LANE_W;
      assign lane_a[i] = opa[TOP -: LANE_W];
      assign put_out[TOP -: LANE_W] = (ptr == PTR_W'(i)) ? opb[LANE_W-1:0] : lane_a[i];
   end

   assign get_out = {opb[DATA_W-1:LANE_W], lane_a[ptr]};
endmodule

// File: rtl/shift_lane_unit.sv
module shift_lane_unit #(
   parameter int DATA_W      = 32,
   parameter int LANE_W      = 8,
   parameter int FUNNEL_IMPL = 1,
   localparam int LANES  = DATA_W / LANE_W,
   localparam int CNT_W  = $clog2(DATA_W),
   localparam int PTR_W  = $clog2(LANES),
   localparam int STAT_W = CNT_W + PTR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stat_wr,
   input  logic [STAT_W-1:0] stat_wdata,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              ptr_wr,
   input  logic [PTR_W-1:0]  ptr_wdata,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic [DATA_W-1:0] result
);
   import shift_lane_pkg::*;

   if ((1 << CNT_W) != DATA_W) begin : g_bad_width
      $error("DATA_W must be a power of two");
   end
   if (DATA_W % LANE_W != 0 || (1 << PTR_W) != LANES || LANES < 2) begin : g_bad_lane
      $error("LANE_W must split DATA_W into a power-of-two lane count of at least two");
   end
   if (FUNNEL_IMPL != 0 && FUNNEL_IMPL != 1) begin : g_bad_impl
      $error("FUNNEL_IMPL must be 0 or 1");
   end

   logic [CNT_W-1:0]  cur_cnt;
   logic [PTR_W-1:0]  cur_ptr;
   logic [DATA_W-1:0] funnel_res, get_res, put_res;
   lane_op_e          op_e;

   shift_status_reg #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_stat (
      .clk(clk), .rst(rst),
      .full_wr(stat_wr), .full_data(stat_wdata),
      .cnt_wr(cnt_wr), .cnt_data(cnt_wdata),
      .ptr_wr(ptr_wr), .ptr_data(ptr_wdata),
      .cnt_q(cur_cnt), .ptr_q(cur_ptr)
   );

   funnel_extract #(.DATA_W(DATA_W), .FUNNEL_IMPL(FUNNEL_IMPL)) u_funnel (
      .hi_in(src_a), .lo_in(src_b), .cnt(cur_cnt), .out(funnel_res)
   );

   lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lane (
      .opa(src_a), .opb(src_b), .ptr(cur_ptr),
      .get_out(get_res), .put_out(put_res)
   );

   assign op_e = lane_op_e'(op);

   always_comb begin
      unique case (op_e)
         OP_FUNNEL:   result = funnel_res;
         OP_BYTE_GET: result = get_res;
         OP_BYTE_PUT: result = put_res;
         default:     result = '0;
      endcase
   end

   assert_zero_count_R7: assert property (@(posedge clk) disable iff (rst)
      (op == 2'd0 && cur_cnt == '0) |-> (result == src_a));

   assert_rotate_R8: assert property (@(posedge clk) disable iff (rst)
      (op == 2'd0 && src_a == src_b && cur_cnt != '0)
         |-> (result == ((src_a << cur_cnt) | (src_a >> (DATA_W - int'(cur_cnt))))));

   assert_get_keeps_high_R9: assert property (@(posedge clk) disable iff (rst)
      (op == 2'd1) |-> (result[DATA_W-1:LANE_W] == src_b[DATA_W-1:LANE_W]));

   assert_put_lane_count_R10: assert property (@(posedge clk) disable iff (rst)
      (op == 2'd2 && src_b[LANE_W-1:0] != src_a[DATA_W-1-int'(cur_ptr)*LANE_W -: LANE_W])
         |-> ($countones(result ^ src_a) != 0));

   assert_unused_op_R11: assert property (@(posedge clk) disable iff (rst)
      (op == 2'd3) |-> (result == '0));
endmodule

// File: tb/shift_lane_unit_test.sv
`timescale 1ns/1ps
module shift_lane_unit_test #(parameter int FUNNEL_IMPL = 1);
   logic        clk = 0;
   logic        rst = 1;
   logic        stat_wr = 0, cnt_wr = 0, ptr_wr = 0;
   logic [6:0]  stat_wdata = '0;
   logic [4:0]  cnt_wdata = '0;
   logic [1:0]  ptr_wdata = '0;
   logic [1:0]  op = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [31:0] result;

   int total = 0, bad = 0;
   int m_cnt = 0, m_ptr = 0;

   always #2.5 clk = ~clk;

   shift_lane_unit #(.FUNNEL_IMPL(FUNNEL_IMPL)) uut (
      .clk(clk), .rst(rst), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
      .op(op), .src_a(src_a), .src_b(src_b), .result(result)
   );

   function automatic logic [31:0] ref_op(int o, logic [31:0] a, logic [31:0] b, int c, int p);
      logic [63:0] w;
      int sh;
      sh = 24 - 8 * p;
      case (o)
         0: begin w = {a, b} << c; return w[63:32]; end
         1: return (b & 32'hFFFF_FF00) | ((a >> sh) & 32'h0000_00FF);
         2: return (a & ~(32'h0000_00FF << sh)) | ((b & 32'h0000_00FF) << sh);
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic run_op(string req, int o, logic [31:0] a, logic [31:0] b);
      @(negedge clk);
      op = 2'(o); src_a = a; src_b = b;
      #1 check(req, result, ref_op(o, a, b, m_cnt, m_ptr));
   endtask

   // drive strobes at negedge, model updates after the edge
   task automatic write(bit fw, logic [6:0] fv, bit cw, logic [4:0] cv, bit pw, logic [1:0] pv);
      @(negedge clk);
      stat_wr = fw; stat_wdata = fv; cnt_wr = cw; cnt_wdata = cv; ptr_wr = pw; ptr_wdata = pv;
      @(posedge clk);
      if (rst) begin m_cnt = 0; m_ptr = 0; end
      else if (fw) begin m_cnt = int'(fv[4:0]); m_ptr = int'(fv[6:5]); end
      else begin
         if (cw) m_cnt = int'(cv);
         if (pw) m_ptr = int'(pv);
      end
      #1 stat_wr = 0; cnt_wr = 0; ptr_wr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] x, t, u, rev;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 0;
      // R4: reset state count 0 pointer 0
      run_op("R4", 0, 32'h1234_5678, 32'h9ABC_DEF0);
      run_op("R4", 1, 32'hA1B2_C3D4, 32'h5566_7788);
      // R1: full write of 56
      write(1, 7'd56, 0, 0, 0, 0);
      run_op("R1", 0, 32'hAABB_CCDD, 32'hAABB_CCDD);
      check("R8", result, 32'hDDAA_BBCC);
      run_op("R1", 1, 32'hDDAA_BBCC, 32'hDDAA_BBCC);
      check("R9", result, 32'hDDAA_BBAA);
      run_op("R10", 2, 32'hDDAA_BBAA, 32'hDDAA_BBCC);
      check("R10", result, 32'hDDCC_BBAA);
      // R2: field strobes alone
      write(0, 0, 1, 5'd3, 0, 0);
      run_op("R2", 1, 32'h1122_3344, 32'hFFFF_FF00);
      run_op("R2", 0, 32'h1122_3344, 32'h8899_AABB);
      write(0, 0, 0, 0, 1, 2'd3);
      run_op("R2", 0, 32'h1122_3344, 32'h8899_AABB);
      run_op("R2", 2, 32'h1122_3344, 32'h0000_0077);
      // R3: full write wins over field strobes
      write(1, {2'd2, 5'd9}, 1, 5'd30, 1, 2'd0);
      run_op("R3", 0, 32'hCAFE_F00D, 32'h0BAD_BEEF);
      run_op("R3", 1, 32'hCAFE_F00D, 32'h0BAD_BEEF);
      // R5: before the edge the old count is still used
      @(negedge clk);
      cnt_wr = 1; cnt_wdata = 5'd17; op = 2'd0; src_a = 32'h8000_0001; src_b = 32'h7FFF_FFFE;
      #1 check("R5", result, ref_op(0, src_a, src_b, m_cnt, m_ptr));
      @(posedge clk); m_cnt = 17;
      #1 cnt_wr = 0;
      run_op("R5", 0, 32'h8000_0001, 32'h7FFF_FFFE);
      // R4: reset wins over a simultaneous write
      @(negedge clk) rst = 1;
      write(1, 7'd127, 0, 0, 0, 0);
      @(negedge clk) rst = 0;
      run_op("R4", 0, 32'h0F0F_0F0F, 32'hF0F0_F0F0);
      // R6 R7 R8 R9 R10 R11: sweep every count and pointer
      for (int c = 0; c < 32; c++) begin
         for (int p = 0; p < 4; p++) begin
            write(1, 7'((p << 5) + c), 0, 0, 0, 0);
            x = $urandom; t = $urandom;
            run_op((c == 0) ? "R7" : "R6", 0, x, t);
            run_op("R8", 0, x, x);
            run_op("R9", 1, x, t);
            run_op("R10", 2, x, t);
            run_op("R11", 3, x, t);
         end
      end
      // R12: byte reverse sequence on random words
      write(1, 7'd56, 0, 0, 0, 0);
      for (int n = 0; n < 40; n++) begin
         x = $urandom;
         rev = {x[7:0], x[15:8], x[23:16], x[31:24]};
         @(negedge clk); op = 2'd0; src_a = x; src_b = x;
         #1 t = result;
         @(negedge clk); op = 2'd1; src_a = t; src_b = t;
         #1 u = result;
         @(negedge clk); op = 2'd2; src_a = u; src_b = t;
         #1 check("R12", result, rev);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule